// File: doc/BRIEF.md
# Deep Standby Pin Retention Controller

This block freezes the chip's pins across a deep-standby power-down and frees them again in a controlled order once the chip wakes. The pins fall into two groups. One group holds the external bus control pins; the other holds every remaining general pin. When the standby entry request arrives, the block captures the present output value and output enable of every pin. From then on the pads drive those captured values, whatever the functional logic presents.

When standby is cancelled, two configuration bits decide what happens. One bit picks the wake-up activation path: the external bus, or on-chip RAM whose contents were kept. The other bit picks whether the bus control group stays frozen. The general group is freed only when software clears a keep flag, which hardware sets on standby entry. The bus control group is freed either at the moment of wake or, when configured to stay frozen, together with the general group. The combination "bus control pins stay frozen, activate from the external bus" is illegal. A write of it is refused.

Which pins count as bus control depends on the bus width strap. In 16-bit mode the group is address bits 20..0, data bits 15..0, chip select 0, read strobe and bus clock. In 32-bit mode it is address bits 20..2, data bits 31..0 and the same three control pins.

Top module: `pin_retention_ctrl`

## Requirements
- R1: After power-on reset, no pin is held, both configuration bits and the keep flag read 0, the error flag reads 0, and every pad follows its functional output and enable.
- R2: An accepted standby entry captures the functional output and enable of all pins on that clock edge. While a pin is held, its pad drives the captured pair and ignores changes on the functional inputs.
- R3: An accepted standby entry sets `stby_o` and `io_keep_o` to 1 on the same edge.
- R4: A register write to address 0 loads `ram_boot` from data bit 0 and `bus_keep_en` from data bit 1 when the pair is legal.
- R5: A write to address 0 with bit 1 = 1 and bit 0 = 0 is rejected. Both configuration bits keep their values, and `cfg_err_o` becomes 1 and stays 1 until reset.
- R6: On an accepted standby exit with `bus_keep_en` = 0, the bus control group is released on that edge and the general group stays held.
- R7: On an accepted standby exit with `bus_keep_en` = 1, the bus control group stays held until the keep flag is cleared. Both groups are then released on the same edge.
- R8: The keep flag is cleared only by writing 0 to bit 0 of address 1 outside standby. Writing 1 there has no effect.
- R9: The general group is released on the edge that clears the keep flag, in every legal configuration.
- R10: Pin index layout: 0..20 address, 21..52 data 0..31, 53 chip select 0, 54 read strobe, 55 bus clock, 56 and up general. With `bus_mode_i` = 0, data 16..31 (indices 37..52) belong to the general group. With `bus_mode_i` = 1, address 0..1 (indices 0..1) belong to the general group.
- R11: An accepted standby exit makes `wake_o` 1 for exactly one cycle and loads `boot_ram_o` with the `ram_boot` value in force at exit.
- R12: An entry request while in standby, an exit request outside standby, and any register write during standby are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| bus_mode_i | input | 1 | Bus width strap: 0 = 16-bit, 1 = 32-bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register address: 0 = configuration, 1 = keep control |
| wr_data_i | input | 2 | Register write data |
| stby_enter_i | input | 1 | Deep-standby entry request |
| stby_exit_i | input | 1 | Deep-standby cancel request |
| func_out_i | input | PIN_W | Functional pin output values |
| func_oe_i | input | PIN_W | Functional pin output enables |
| pad_out_o | output | PIN_W | Output values to pads |
| pad_oe_o | output | PIN_W | Output enables to pads |
| stby_o | output | 1 | In deep standby |
| wake_o | output | 1 | One-cycle pulse on standby exit |
| boot_ram_o | output | 1 | Activation path captured at exit: 1 = retained RAM |
| ram_boot_o | output | 1 | Configuration: activate from RAM |
| bus_keep_o | output | 1 | Configuration: keep bus control pins frozen |
| io_keep_o | output | 1 | Keep flag |
| cfg_err_o | output | 1 | Sticky flag for a rejected configuration write |

## Verification
The retention cycle runs in both bus widths for each of the three legal configurations. Every pin gets one pattern at entry and a different pattern while held. A pad showing the later pattern too early marks a pin freed in the wrong group or at the wrong moment. Because the two width modes move different index ranges between the groups, they expose a wrong membership boundary. The keep-flag clear step separates an early bus release (keep 0) from a joint release (keep 1). Directed cases cover the illegal write, writing 1 to the keep flag, a repeated entry, and writes made during standby.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int ADDR_W     = 21;
  localparam int DATA_W     = 32;
  localparam int DATA_LO    = ADDR_W;            // 21
  localparam int CTRL_LO    = ADDR_W + DATA_W;   // 53
  localparam int BUS_REGION = CTRL_LO + 3;       // 56

  localparam logic REG_CFG  = 1'b0;
  localparam logic REG_KEEP = 1'b1;

  typedef enum logic { BUS16 = 1'b0, BUS32 = 1'b1 } bus_mode_e;

  function automatic logic [BUS_REGION-1:0] bus_group_mask(input bus_mode_e mode);
    logic [BUS_REGION-1:0] m;
    m = '1;
    if (mode == BUS16) m[DATA_LO+DATA_W-1 : DATA_LO+16] = '0;
    else               m[1:0] = '0;
    return m;
  endfunction
endpackage

// File: rtl/dsr_cfg_regs.sv
module dsr_cfg_regs
  import dsr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [1:0] wr_data_i,
  input  logic       stby_i,
  input  logic       enter_i,
  output logic       ram_boot_o,
  output logic       bus_keep_o,
  output logic       io_keep_o,
  output logic       cfg_err_o,
  output logic       keep_clr_o
);
  logic ram_boot_q, bus_keep_q, io_keep_q, err_q;
  logic wr_ok, cfg_wr, illegal;

  assign wr_ok      = wr_en_i && !stby_i;
  assign cfg_wr     = wr_ok && (wr_addr_i == REG_CFG);
  assign illegal    = wr_data_i[1] && !wr_data_i[0];
  assign keep_clr_o = wr_ok && (wr_addr_i == REG_KEEP) && !wr_data_i[0] && io_keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_boot_q <= 1'b0;
      bus_keep_q <= 1'b0;
      err_q      <= 1'b0;
    end else if (cfg_wr) begin
      if (illegal) err_q <= 1'b1;
      else begin
        ram_boot_q <= wr_data_i[0];
        bus_keep_q <= wr_data_i[1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         io_keep_q <= 1'b0;
    else if (enter_i)    io_keep_q <= 1'b1;
    else if (keep_clr_o) io_keep_q <= 1'b0;
  end

  assign ram_boot_o = ram_boot_q;
  assign bus_keep_o = bus_keep_q;
  assign io_keep_o  = io_keep_q;
  assign cfg_err_o  = err_q;

  assert_cfg_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_keep_q && !ram_boot_q));

  assert_reject_keeps_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && illegal) |=> ($stable(ram_boot_q) && $stable(bus_keep_q) && err_q));

  assert_keep_write1_noop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_addr_i == REG_KEEP && wr_data_i[0] && !enter_i) |=> $stable(io_keep_q));

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/dsr_hold_ctrl.sv
module dsr_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_enter_i,
  input  logic stby_exit_i,
  input  logic ram_boot_i,
  input  logic bus_keep_i,
  input  logic keep_clr_i,
  output logic enter_o,
  output logic stby_o,
  output logic bus_hold_o,
  output logic gen_hold_o,
  output logic wake_o,
  output logic boot_ram_o
);
  logic stby_q, bus_hold_q, gen_hold_q, wake_q, boot_ram_q, exit_ok;

  assign enter_o = stby_enter_i && !stby_q;
  assign exit_ok = stby_exit_i && stby_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stby_q     <= 1'b0;
      bus_hold_q <= 1'b0;
      gen_hold_q <= 1'b0;
      wake_q     <= 1'b0;
      boot_ram_q <= 1'b0;
    end else begin
      wake_q <= exit_ok;
      if (enter_o) begin
        stby_q     <= 1'b1;
        bus_hold_q <= 1'b1;
        gen_hold_q <= 1'b1;
      end else if (exit_ok) begin
        stby_q     <= 1'b0;
        boot_ram_q <= ram_boot_i;
        if (!bus_keep_i) bus_hold_q <= 1'b0;
      end else if (keep_clr_i) begin
        bus_hold_q <= 1'b0;
        gen_hold_q <= 1'b0;
      end
    end
  end

  assign stby_o     = stby_q;
  assign bus_hold_o = bus_hold_q;
  assign gen_hold_o = gen_hold_q;
  assign wake_o     = wake_q;
  assign boot_ram_o = boot_ram_q;

  assert_enter_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> (stby_q && bus_hold_q && gen_hold_q));

  assert_exit_frees_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_ok && !bus_keep_i) |=> (!bus_hold_q && gen_hold_q));

  assert_exit_keeps_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_ok && bus_keep_i) |=> bus_hold_q);

  assert_gen_release_on_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gen_hold_q) |-> $past(keep_clr_i));

  assert_wake_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q);
endmodule

// File: rtl/dsr_pin_hold.sv
module dsr_pin_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [W-1:0] hold_i,
  input  logic [W-1:0] func_out_i,
  input  logic [W-1:0] func_oe_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  logic [W-1:0] lat_out_q, lat_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_out_q <= '0;
      lat_oe_q  <= '0;
    end else if (capture_i) begin
      lat_out_q <= func_out_i;
      lat_oe_q  <= func_oe_i;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out_o[i] = hold_i[i] ? lat_out_q[i] : func_out_i[i];
    assign pad_oe_o[i]  = hold_i[i] ? lat_oe_q[i]  : func_oe_i[i];
  end

  assert_held_pads_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hold_i & $past(hold_i) & ((pad_out_o ^ $past(pad_out_o)) | (pad_oe_o ^ $past(pad_oe_o)))) == '0));
endmodule

// File: rtl/pin_retention_ctrl.sv
module pin_retention_ctrl
  import dsr_pkg::*;
#(
  parameter int GEN_W = 8,
  localparam int PIN_W = BUS_REGION + GEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_mode_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [1:0]       wr_data_i,
  input  logic             stby_enter_i,
  input  logic             stby_exit_i,
  input  logic [PIN_W-1:0] func_out_i,
  input  logic [PIN_W-1:0] func_oe_i,
  output logic [PIN_W-1:0] pad_out_o,
  output logic [PIN_W-1:0] pad_oe_o,
  output logic             stby_o,
  output logic             wake_o,
  output logic             boot_ram_o,
  output logic             ram_boot_o,
  output logic             bus_keep_o,
  output logic             io_keep_o,
  output logic             cfg_err_o
);
  logic enter, keep_clr, bus_hold, gen_hold;
  logic [BUS_REGION-1:0] bus_mask;
  logic [PIN_W-1:0] hold;

  dsr_cfg_regs i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .stby_i(stby_o), .enter_i(enter),
    .ram_boot_o, .bus_keep_o, .io_keep_o, .cfg_err_o,
    .keep_clr_o(keep_clr)
  );

  dsr_hold_ctrl i_ctrl (
    .clk_i, .rst_ni, .stby_enter_i, .stby_exit_i,
    .ram_boot_i(ram_boot_o), .bus_keep_i(bus_keep_o), .keep_clr_i(keep_clr),
    .enter_o(enter), .stby_o, .bus_hold_o(bus_hold), .gen_hold_o(gen_hold),
    .wake_o, .boot_ram_o
  );

  assign bus_mask = bus_group_mask(bus_mode_e'(bus_mode_i));

  for (genvar i = 0; i < PIN_W; i++) begin : g_hold
    if (i < BUS_REGION) begin : g_bus_region
      assign hold[i] = bus_mask[i] ? bus_hold : gen_hold;
    end else begin : g_general
      assign hold[i] = gen_hold;
    end
  end

  dsr_pin_hold #(.W(PIN_W)) i_pins (
    .clk_i, .rst_ni, .capture_i(enter), .hold_i(hold),
    .func_out_i, .func_oe_i, .pad_out_o, .pad_oe_o
  );

  assert_keep_tracks_gen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_o && gen_hold) |-> io_keep_o);

  assert_no_write_in_stby_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_o && !stby_exit_i) |=> ($stable(ram_boot_o) && $stable(bus_keep_o) && io_keep_o));
endmodule

// File: tb/test_pin_retention_ctrl.sv
module test_pin_retention_ctrl;
  localparam int GEN_W = 8;
  localparam int PIN_W = 56 + GEN_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_mode = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [1:0] wr_data = '0;
  logic enter = 1'b0, leave = 1'b0;
  logic [PIN_W-1:0] fout = '0, foe = '0, pout, poe;
  logic stby, wake, boot_ram, ram_boot, bus_keep, io_keep, err;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pin_retention_ctrl #(.GEN_W(GEN_W)) i_pin_retention_ctrl (
    .clk_i(clk), .rst_ni, .bus_mode_i(bus_mode), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .stby_enter_i(enter), .stby_exit_i(leave),
    .func_out_i(fout), .func_oe_i(foe), .pad_out_o(pout), .pad_oe_o(poe),
    .stby_o(stby), .wake_o(wake), .boot_ram_o(boot_ram), .ram_boot_o(ram_boot),
    .bus_keep_o(bus_keep), .io_keep_o(io_keep), .cfg_err_o(err)
  );

  // {bus_mode, bus_keep_en, ram_boot}
  localparam logic [2:0] VEC [6] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101, 3'b111};
  localparam logic [PIN_W-1:0] PAT_A  = 64'hA5C3_0F96_5A3C_F069;
  localparam logic [PIN_W-1:0] PAT_B  = 64'h3C5A_96F0_C3A5_690F;
  localparam logic [PIN_W-1:0] OE_A   = 64'hFFFF_0000_FF00_F0F0;
  localparam logic [PIN_W-1:0] OE_B   = 64'h0000_FFFF_00FF_0F0F;

  function automatic logic [PIN_W-1:0] bus_pins(input logic mode);
    logic [PIN_W-1:0] m = '0;
    for (int i = 0; i < PIN_W; i++) begin
      if (i <= 20)      m[i] = (mode == 1'b0) || (i >= 2);
      else if (i <= 52) m[i] = (mode == 1'b1) || (i <= 36);
      else if (i <= 55) m[i] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [PIN_W-1:0] act, input logic [PIN_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_enter();
    @(negedge clk); enter = 1'b1;
    @(negedge clk); enter = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); leave = 1'b1;
    @(negedge clk); leave = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    #500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [PIN_W-1:0] m, eo, ee;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    fout = PAT_A; foe = OE_A;
    @(negedge clk);
    // R1 reset state
    check("R1 pads", pout, PAT_A);
    check("R1 oe", poe, OE_A);
    check("R1 flags", {58'd0, stby, ram_boot, bus_keep, io_keep, err, wake}, '0);

    foreach (VEC[k]) begin
      do_reset();
      bus_mode = VEC[k][2];
      m = bus_pins(VEC[k][2]);
      fout = PAT_A; foe = OE_A;
      wr(1'b0, VEC[k][1:0]);
      check("R4 cfg", {62'd0, bus_keep, ram_boot}, {62'd0, VEC[k][1:0]});
      pulse_enter();
      check("R3 stby/keep", {62'd0, stby, io_keep}, 64'd3);
      fout = PAT_B; foe = OE_B;
      @(negedge clk);
      check("R2 held out", pout, PAT_A);
      check("R2 held oe", poe, OE_A);
      pulse_exit();
      check("R11 wake/boot", {62'd0, wake, boot_ram}, {62'd0, 1'b1, VEC[k][0]});
      eo = VEC[k][1] ? PAT_A : ((m & PAT_B) | (~m & PAT_A));
      ee = VEC[k][1] ? OE_A  : ((m & OE_B)  | (~m & OE_A));
      @(negedge clk);
      check("R11 wake pulse", {63'd0, wake}, '0);
      check(VEC[k][1] ? "R7 bus kept out" : "R6 R10 bus freed out", pout, eo);
      check(VEC[k][1] ? "R7 bus kept oe"  : "R6 R10 bus freed oe", poe, ee);
      wr(1'b1, 2'b01);
      check("R8 write1 noop", {63'd0, io_keep}, 64'd1);
      check("R9 still held", pout, eo);
      wr(1'b1, 2'b00);
      check("R8 keep cleared", {63'd0, io_keep}, '0);
      check("R9 R7 released out", pout, PAT_B);
      check("R9 R7 released oe", poe, OE_B);
    end

    // R5 illegal configuration
    do_reset();
    wr(1'b0, 2'b01);
    wr(1'b0, 2'b10);
    check("R5 cfg kept", {62'd0, bus_keep, ram_boot}, 64'd1);
    check("R5 err set", {63'd0, err}, 64'd1);
    wr(1'b0, 2'b11);
    check("R5 err sticky", {61'd0, err, bus_keep, ram_boot}, 64'd7);

    // R12 ignored requests and writes
    do_reset();
    bus_mode = 1'b0;
    pulse_exit();
    check("R12 exit outside stby", {62'd0, stby, wake}, '0);
    fout = PAT_A; foe = OE_A;
    pulse_enter();
    fout = PAT_B; foe = OE_B;
    pulse_enter();
    check("R12 re-entry no recapture", pout, PAT_A);
    wr(1'b0, 2'b01);
    wr(1'b1, 2'b00);
    check("R12 writes in stby", {61'd0, ram_boot, io_keep, stby}, 64'd3);
    pulse_exit();
    check("R12 boot after ignored write", {63'd0, boot_ram}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule